// File: doc/BRIEF.md
# Masked Fibonacci Pseudonoise Generator

This block produces a pseudorandom bit stream from a linear-feedback shift register of degree `DEG`, arranged in the simple (Fibonacci) form. The feedback taps, the starting contents and an output mask are taken from input ports. They are captured only when the block is reset or reloaded. Each enabled step shifts the register by one place. The output bit is the modulo-2 sum of the cells that the mask selects. A mask equal to z^d mod g(z) therefore gives the stream advanced by d steps. A mask of 1 gives the stream itself.

A reload input restarts the sequence from the captured seed, and it also discards any partial word. An optional packer, chosen at elaboration time, gathers `PACK_W` consecutive output bits into a 32-bit word. The earliest bit lands in the most significant packed position. When `PACK_SIGNED` is set, the word is sign-extended; otherwise it is zero-extended. A one-cycle valid pulse marks each finished word.

A polynomial whose top or bottom coefficient is 0 is refused. The block flags the error and stays silent until a valid polynomial is reloaded.

Top module: `pn_gen`

## Requirements
- R1: While `rst_n` is low, or in a cycle with `reload` high, the block captures `seed_in`, `poly_in` and `mask_in`. Seed bit k becomes stream element x_k. On the next cycle `bit_out` equals the masked sum of the seed, `word_vld` is 0 and the packer holds no bits.
- R2: Each clock edge with `step_en` high advances the stream by one element. The stream obeys x_(n+DEG) = XOR over k < DEG of (g_k AND x_(n+k)), where g_k is `poly_in` bit k.
- R3: With `step_en` low, the register holds, and so `bit_out` keeps its value.
- R4: `bit_out` at step T equals XOR over k of (m_k AND x_(T+k)), where m_k is `mask_in` bit k. A mask with only bit d set yields x_(T+d), and a mask of 1 yields x_T.
- R5: When `reload` and `step_en` are both high in the same cycle, the reload wins. The stream restarts at x_0 and no word is emitted.
- R6: A change on `poly_in`, `seed_in` or `mask_in` between loads has no effect on the output.
- R7: A captured polynomial with bit `DEG` or bit 0 equal to 0 raises `cfg_err`. While `cfg_err` is high, `bit_out` is 0, steps are ignored and `word_vld` stays 0.
- R8: An all-zero seed gives a `bit_out` of 0 on every step.
- R9: With `DEG`=6 and the primitive polynomial z^6+z+1 (`poly_in`=7'b1000011), any nonzero seed produces a stream of period 63 that holds exactly 32 ones per period.
- R10: Every `PACK_W`-th step after a load completes a word. On the cycle after that step, `word_vld` is 1 for one cycle. `word_out[PACK_W-1:0]` then holds the bits of those steps, earliest bit in bit `PACK_W-1`.
- R11: `word_out[31:PACK_W]` is a copy of bit `PACK_W-1` when `PACK_SIGNED`=1, and is 0 when `PACK_SIGNED`=0.
- R12: A reload discards a partial word. The next word is completed by the `PACK_W`-th step after the reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also captures the configuration |
| step_en | input | 1 | Advance the register by one step |
| reload | input | 1 | Restart from seed and capture the configuration |
| poly_in | input | DEG+1 | Feedback polynomial, bit k = g_k |
| seed_in | input | DEG | Initial register contents, bit k = x_k |
| mask_in | input | DEG | Output mask, bit k = m_k |
| bit_out | output | 1 | Masked sequence bit for the current step |
| cfg_err | output | 1 | Captured polynomial lacks its top or constant term |
| word_out | output | 32 | Packed word, extended to 32 bits |
| word_vld | output | 1 | One-cycle pulse when a word is complete |

## Verification
On every cycle, the assertions check the register's local behaviour: a load copies the seed, a step moves each cell into its lower neighbour, an idle or refused step holds the register, a zero register stays zero, the packer's counter stays in range, and no word appears while the polynomial is refused. Whole-sequence properties can be shown only by the bench's scenarios, which sweep every nonzero seed and several masks against an arithmetic model of the recurrence. Those properties are the mask's advance by d, the period and balance of the maximal sequence, the ordering and extension of packed words, and reload priority and mid-sequence input changes.

// File: rtl/pn_pkg.sv
// Package pn_pkg: constants and helpers shared by the pseudonoise generator.
// Assumes: packed words never exceed the 32-bit output port.
package pn_pkg;
    localparam int WORD_W = 32;

    // A usable feedback polynomial needs its top and constant terms.
    function automatic logic poly_valid(input logic top_term, input logic const_term);
        return top_term & const_term;
    endfunction
endpackage

// File: rtl/pn_lfsr_core.sv
// Module pn_lfsr_core: Fibonacci shift register holding x_T..x_(T+DEG-1),
// with cell k = x_(T+k). It captures seed and polynomial on reset or load.
// Assumes: DEG >= 2. Steps are refused while the captured polynomial is invalid.
module pn_lfsr_core #(
    parameter int DEG = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [DEG-1:0] seed_in,
    input  logic [DEG:0]   poly_in,
    output logic [DEG-1:0] state,
    output logic           cfg_err
);
    import pn_pkg::*;

    logic [DEG:0] poly_q;
    logic         fb;

    // Feedback: modulo-2 sum of the tapped cells.
    always_comb fb = ^(poly_q[DEG-1:0] & state);

    // Error flag from the captured polynomial's end terms.
    always_comb cfg_err = !poly_valid(poly_q[DEG], poly_q[0]);

    // Capture the configuration on reset or load, otherwise shift on a step.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            state  <= seed_in;
            poly_q <= poly_in;
        end else if (step && !cfg_err) begin
            state  <= {fb, state[DEG-1:1]};
        end
    end

    assert_load_seed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state == $past(seed_in));
    assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !cfg_err) |=> state[DEG-2:0] == $past(state[DEG-1:1]));
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(state));
    assert_bad_poly_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !load) |=> $stable(state));
    assert_zero_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == '0 && !load) |=> state == '0);
endmodule

// File: rtl/pn_mask_comb.sv
// Module pn_mask_comb: captures the output mask on reset or load and forms the
// output bit as the parity of the masked register cells.
// Assumes: the mask already encodes z^d mod g(z) for the wanted advance d.
module pn_mask_comb #(
    parameter int DEG = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [DEG-1:0] mask_in,
    input  logic [DEG-1:0] state,
    input  logic           enable,
    output logic           bit_out
);
    logic [DEG-1:0] mask_q;

    // Hold the mask between loads so mid-sequence changes are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n || load) mask_q <= mask_in;
    end

    // Output bit: parity of the selected cells, silenced when disabled.
    always_comb bit_out = enable & (^(state & mask_q));
endmodule

// File: rtl/pn_packer.sv
// Module pn_packer: gathers W successive bits, earliest bit in the MSB, and
// presents each finished word extended to 32 bits, with a one-cycle valid pulse.
// Assumes: 1 <= W <= 32. With ENABLE=0 the outputs are tied to 0.
module pn_packer #(
    parameter int W       = 5,
    parameter bit SIGNED  = 1'b1,
    parameter bit ENABLE  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        shift,
    input  logic        bit_in,
    output logic [31:0] word_out,
    output logic        word_vld
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    generate
        if (ENABLE) begin : g_pack
            logic [W-1:0]  acc;
            logic [W-1:0]  acc_nx;
            logic [W-1:0]  word_q;
            logic [CW-1:0] cnt;
            logic          vld_q;

            // Next accumulator value with the new bit appended at the bottom.
            always_comb acc_nx = (acc << 1) | W'(bit_in);

            // Collect bits and publish a word once W of them are in.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc    <= '0;
                    cnt    <= '0;
                    vld_q  <= 1'b0;
                    word_q <= '0;
                end else if (clr) begin
                    acc    <= '0;
                    cnt    <= '0;
                    vld_q  <= 1'b0;
                end else begin
                    vld_q <= 1'b0;
                    if (shift) begin
                        if (cnt == LAST) begin
                            word_q <= acc_nx;
                            vld_q  <= 1'b1;
                            acc    <= '0;
                            cnt    <= '0;
                        end else begin
                            acc <= acc_nx;
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            end

            for (genvar i = 0; i < 32; i++) begin : g_ext
                if (i < W) begin : g_data
                    assign word_out[i] = word_q[i];
                end else begin : g_fill
                    assign word_out[i] = SIGNED ? word_q[W-1] : 1'b0;
                end
            end
            assign word_vld = vld_q;

            assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
                cnt <= LAST);
            assert_vld_after_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
                vld_q |-> $past(shift));
        end else begin : g_nopack
            assign word_out = '0;
            assign word_vld = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/pn_gen.sv
// Module pn_gen: masked Fibonacci pseudonoise generator with reload and an
// optional bit packer. Polynomial, seed and mask are captured on reset/reload.
// Assumes: DEG >= 2, 1 <= PACK_W <= 32; reload outranks step_en.
module pn_gen #(
    parameter int DEG         = 6,
    parameter int PACK_W      = 5,
    parameter bit PACK_SIGNED = 1'b1,
    parameter bit PACK_EN     = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_en,
    input  logic           reload,
    input  logic [DEG:0]   poly_in,
    input  logic [DEG-1:0] seed_in,
    input  logic [DEG-1:0] mask_in,
    output logic           bit_out,
    output logic           cfg_err,
    output logic [31:0]    word_out,
    output logic           word_vld
);
    logic [DEG-1:0] state;
    logic           pack_shift;

    pn_lfsr_core #(.DEG(DEG)) u_core (
        .clk(clk), .rst_n(rst_n), .load(reload), .step(step_en),
        .seed_in(seed_in), .poly_in(poly_in), .state(state), .cfg_err(cfg_err)
    );

    pn_mask_comb #(.DEG(DEG)) u_mask (
        .clk(clk), .rst_n(rst_n), .load(reload), .mask_in(mask_in),
        .state(state), .enable(!cfg_err), .bit_out(bit_out)
    );

    // A packed bit is taken only on a step that really advances the register.
    always_comb pack_shift = step_en && !reload && !cfg_err;

    pn_packer #(.W(PACK_W), .SIGNED(PACK_SIGNED), .ENABLE(PACK_EN)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(reload), .shift(pack_shift),
        .bit_in(bit_out), .word_out(word_out), .word_vld(word_vld)
    );

    assert_no_word_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !word_vld);
    assert_reload_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !word_vld);
endmodule

// File: tb/tb_pn_gen.sv
`timescale 1ns/1ps
module tb_pn_gen;
    localparam int DEG = 6;
    localparam int PW  = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           step_en = 1'b0;
    logic           reload = 1'b0;
    logic [DEG:0]   poly_in = 7'b1000011;
    logic [DEG-1:0] seed_in = 6'h01;
    logic [DEG-1:0] mask_in = 6'h01;
    logic           bit_out, cfg_err, word_vld;
    logic [31:0]    word_out;
    logic           bit_u, err_u, vld_u;
    logic [31:0]    word_u;

    int total = 0;
    int bad = 0;
    int tcur = 0;
    logic [DEG-1:0] cur_mask;
    logic xs [0:255];

    always #2.5 clk = ~clk;

    pn_gen #(.DEG(DEG), .PACK_W(PW), .PACK_SIGNED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .reload(reload),
        .poly_in(poly_in), .seed_in(seed_in), .mask_in(mask_in),
        .bit_out(bit_out), .cfg_err(cfg_err), .word_out(word_out), .word_vld(word_vld)
    );

    pn_gen #(.DEG(DEG), .PACK_W(1), .PACK_SIGNED(1'b0)) dut_u (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .reload(reload),
        .poly_in(poly_in), .seed_in(seed_in), .mask_in(mask_in),
        .bit_out(bit_u), .cfg_err(err_u), .word_out(word_u), .word_vld(vld_u)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0d actual=%h expected=%h", tag, tcur, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Reference stream from the recurrence, seed bit k = x_k.
    task automatic build_ref(input logic [DEG-1:0] s, input logic [DEG:0] g);
        for (int n = 0; n < 256; n++) begin
            if (n < DEG) xs[n] = s[n];
            else begin
                logic acc = 1'b0;
                for (int k = 0; k < DEG; k++) acc ^= g[k] & xs[n-DEG+k];
                xs[n] = acc;
            end
        end
    endtask

    function automatic logic exp_bit(input int t);
        logic acc = 1'b0;
        for (int k = 0; k < DEG; k++) acc ^= cur_mask[k] & xs[t+k];
        return acc;
    endfunction

    task automatic do_load(input logic [DEG-1:0] s, input logic [DEG:0] g, input logic [DEG-1:0] m);
        seed_in = s; poly_in = g; mask_in = m;
        reload = 1'b1; step_en = 1'b0;
        tick();
        reload = 1'b0;
        build_ref(s, g);
        cur_mask = m;
        tcur = 0;
    endtask

    // One step, then check the packed outputs of both instances (R10, R11, R12).
    task automatic step_check();
        step_en = 1'b1;
        tick();
        step_en = 1'b0;
        tcur++;
        if (tcur % PW == 0) begin
            logic [31:0] ew = '0;
            for (int j = 0; j < PW; j++) ew[PW-1-j] = exp_bit(tcur - PW + j);
            for (int j = PW; j < 32; j++) ew[j] = ew[PW-1];
            chk("R10 word_vld", {31'b0, word_vld}, 32'd1);
            chk("R11 R12 word_out signed", word_out, ew);
        end else begin
            chk("R10 no word_vld", {31'b0, word_vld}, 32'd0);
        end
        chk("R10 width1 vld", {31'b0, vld_u}, 32'd1);
        chk("R11 unsigned word", word_u, {31'b0, exp_bit(tcur - 1)});
    endtask

    task automatic run_steps(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            chk(tag, {31'b0, bit_out}, {31'b0, exp_bit(tcur)});
            step_check();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DEG-1:0] masks [0:5];
        int ones;
        logic first;
        masks[0] = 6'b000010; masks[1] = 6'b000100; masks[2] = 6'b100000;
        masks[3] = 6'b101101; masks[4] = 6'b010011; masks[5] = 6'b111111;

        // R1: reset state with seed 6'b100110 and mask 6'b000110.
        seed_in = 6'b100110; mask_in = 6'b000110; poly_in = 7'b1000011;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset bit_out", {31'b0, bit_out}, 32'd0 ^ (1'b1 ^ 1'b1));
        chk("R1 reset word_vld", {31'b0, word_vld}, 32'd0);
        chk("R1 reset word_out", word_out, 32'd0);
        chk("R1 reset cfg_err", {31'b0, cfg_err}, 32'd0);

        // R2 R4: every nonzero seed with the default mask.
        for (int s = 1; s < 64; s++) begin
            do_load(6'(s), 7'b1000011, 6'h01);
            run_steps(12, "R2 R4 seed sweep");
        end

        // R4: one-hot and mixed masks on two primitive polynomials.
        for (int mi = 0; mi < 6; mi++) begin
            do_load(6'h2B, 7'b1000011, masks[mi]);
            run_steps(40, "R4 mask sweep");
            do_load(6'h15, 7'b1100001, masks[mi]);
            run_steps(40, "R4 mask sweep alt poly");
        end

        // R9: period 63 and 32 ones for the maximal sequence.
        do_load(6'h01, 7'b1000011, 6'h01);
        ones = 0;
        first = bit_out;
        for (int i = 0; i < 63; i++) begin
            ones += int'(bit_out);
            step_check();
        end
        chk("R9 ones per period", 32'(ones), 32'd32);
        chk("R9 period 63", {31'b0, bit_out}, {31'b0, first});

        // R3: idle cycles hold the output and emit no word.
        do_load(6'h33, 7'b1000011, 6'b001001);
        run_steps(3, "R3 before idle");
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R3 idle bit held", {31'b0, bit_out}, {31'b0, exp_bit(tcur)});
            chk("R3 idle no word", {31'b0, word_vld}, 32'd0);
        end
        run_steps(8, "R3 after idle");

        // R6: input changes between loads are ignored.
        do_load(6'h0D, 7'b1000011, 6'b000100);
        run_steps(7, "R6 before change");
        poly_in = 7'b1011011; seed_in = 6'h3F; mask_in = 6'b110000;
        run_steps(20, "R6 after change");

        // R5 R12: reload with a step pending, after a partial word.
        do_load(6'h21, 7'b1000011, 6'h01);
        run_steps(3, "R12 partial");
        step_en = 1'b1; reload = 1'b1;
        tick();
        step_en = 1'b0; reload = 1'b0;
        tcur = 0;
        chk("R5 restart at x0", {31'b0, bit_out}, {31'b0, exp_bit(0)});
        chk("R5 no word on reload", {31'b0, word_vld}, 32'd0);
        run_steps(10, "R12 after reload");

        // R8: zero seed stays silent.
        do_load(6'h00, 7'b1000011, 6'b101011);
        for (int i = 0; i < 10; i++) begin
            chk("R8 zero seed", {31'b0, bit_out}, 32'd0);
            step_check();
        end

        // R7: missing constant term, then missing top term.
        do_load(6'h2A, 7'b1000010, 6'h01);
        chk("R7 err raised g0", {31'b0, cfg_err}, 32'd1);
        for (int i = 0; i < 6; i++) begin
            step_en = 1'b1;
            tick();
            chk("R7 bit silent", {31'b0, bit_out}, 32'd0);
            chk("R7 no word", {31'b0, word_vld}, 32'd0);
            chk("R7 no word width1", {31'b0, vld_u}, 32'd0);
        end
        step_en = 1'b0;
        poly_in = 7'b1000011;
        tick();
        chk("R6 R7 err kept until load", {31'b0, cfg_err}, 32'd1);
        do_load(6'h2A, 7'b0000011, 6'h01);
        chk("R7 err raised gtop", {31'b0, cfg_err}, 32'd1);
        do_load(6'h2A, 7'b1000011, 6'h01);
        chk("R7 err cleared", {31'b0, cfg_err}, 32'd0);
        run_steps(10, "R7 recovered");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule